// File: doc/BRIEF.md
# Audio serial clock generator with direction gating

This block sits beside an audio serial port and supplies its timing. In master mode it divides the audio master clock, which is also the block's own clock, into a serial bit clock and a left/right word clock. Two divider stages are chained. The first divides by 2 or 4 to make the bit clock. The second counts 32, 64 or 128 bit periods to make one word-clock frame. The ratios come either from manual select inputs or from an automatic rule that takes the number of master-clock cycles per sample. In slave mode the block drives neither clock. It brings an external bit clock and word clock into the master-clock domain through a synchronizer and turns them into the same strobe outputs that the data shifters use in master mode.

Clocks run only while the global enable is set and at least one of the transmit and receive enables is set. Whenever that condition drops, every output is forced low and the dividers return to zero. The next start therefore always begins from the same phase. In master mode the bit clock can run freely, or it can be gated low during bit slots beyond the selected sample width in each channel half.

Top module: `aclk_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all outputs are low.
- R2: The unit is active only when `glb_en` is 1 and at least one of `tx_en`, `rx_en` is 1. After any clock edge at which the unit is not active, `bclk_o`, `lrclk_o`, `clk_oe`, `bit_rise`, `bit_fall` and `word_sel` are all 0.
- R3: In master mode with a bit divide D (2 or 4), `bclk_o` has a period of D master-clock cycles: D/2 cycles low, then D/2 cycles high.
- R4: In master mode with a word divide W, `lrclk_o` has a period of D*W cycles. It is low during bit slots 0 to W/2-1 and high during the rest. It changes only on the edge at which the bit clock falls, so `bit_fall` is set in that same cycle.
- R5: On activation the dividers start from zero. `bclk_o` first goes high after the D/2-th active clock edge, and `lrclk_o` starts low.
- R6: When `auto_div` is 1, a cycles-per-sample value in `ratio` above 384 selects D=4 and W=128. Otherwise W=64, with D=2 if `ratio` is below 192 and D=4 if not.
- R7: When `auto_div` is 0, `man_div4` set to 1 selects D=4 and set to 0 selects D=2. `man_wsel` set to 0 selects W=32, set to 1 selects W=64, and set to 2 or 3 selects W=128.
- R8: `clk_oe` is 1 one cycle after an edge at which `master` is 1 and the unit is active, and 0 otherwise. In slave mode `bclk_o` and `lrclk_o` stay 0.
- R9: In slave mode, a change on `ext_bclk` shows up as a one-cycle pulse on `bit_rise` (for a rise) or `bit_fall` (for a fall) after the third clock edge following the change. `word_sel` follows `ext_lrclk` with the same latency.
- R10: In master mode with `free_run` at 0, `bclk_o` is held low during bit slots whose position within the channel half is at least the sample width. `wlen_sel` set to 0 gives a width of 16, set to 1 gives 24, and set to 2 or 3 gives 32. With `free_run` at 1, every bit slot is clocked.
- R11: In master mode, `bit_rise` and `bit_fall` are one-cycle strobes set in the same cycle as the ungated bit clock rises or falls. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| master | input | 1 | 1: generate clocks; 0: take them from external pins |
| free_run | input | 1 | 1: bit clock never gated |
| auto_div | input | 1 | 1: derive ratios from `ratio` |
| ratio | input | RATIO_W | Master-clock cycles per sample, used in automatic mode |
| man_div4 | input | 1 | Manual bit divide: 1 gives 4, 0 gives 2 |
| man_wsel | input | 2 | Manual word divide select |
| wlen_sel | input | 2 | Sample width select for gating |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External word clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock, possibly gated |
| lrclk_o | output | 1 | Generated word clock |
| clk_oe | output | 1 | Output enable for the clock pins |
| bit_rise | output | 1 | Bit clock rising strobe |
| bit_fall | output | 1 | Bit clock falling strobe |
| word_sel | output | 1 | Current channel, 1 for the high half of the frame |

## Verification
Two events can fall on the same master-clock edge: the bit clock's falling edge that closes a channel half, and the word-clock toggle together with the bit-counter wrap at the frame boundary. Runs of full frames in each divider pairing provoke this coincidence. The bench's cycle model then judges `lrclk_o` and `bit_fall` on that exact edge. A disable that lands on a divider tick is also provoked, by dropping the enables at arbitrary phases. The next cycle must show all outputs low, and the following start must reproduce the first rise after exactly D/2 edges.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    WD_32  = 2'd0,
    WD_64  = 2'd1,
    WD_128 = 2'd2
  } wdiv_e;

  localparam int AUTO_HI_THR = 384;
  localparam int AUTO_LO_THR = 192;
endpackage

// File: rtl/aclk_rate_pick.sv
module aclk_rate_pick
  import aclk_pkg::*;
#(
  parameter int RATIO_W = 12
) (
  input  logic               auto_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               man_div4,
  input  logic [1:0]         man_wsel,
  output logic               div4,
  output wdiv_e              wdiv
);
  localparam logic [RATIO_W-1:0] HI_LIM = RATIO_W'(AUTO_HI_THR);
  localparam logic [RATIO_W-1:0] LO_LIM = RATIO_W'(AUTO_LO_THR);

  always_comb begin
    if (auto_en) begin
      if (ratio > HI_LIM) begin
        div4 = 1'b1;
        wdiv = WD_128;
      end else begin
        wdiv = WD_64;
        div4 = (ratio >= LO_LIM);
      end
    end else begin
      div4 = man_div4;
      case (man_wsel)
        2'd0:    wdiv = WD_32;
        2'd1:    wdiv = WD_64;
        default: wdiv = WD_128;
      endcase
    end
  end
endmodule

// File: rtl/aclk_master_div.sv
module aclk_master_div
  import aclk_pkg::*;
#(
  parameter int MAX_BITS = 128,
  parameter int VB_W     = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            div4,
  input  wdiv_e           wdiv,
  input  logic            free_run,
  input  logic [VB_W-1:0] valid_bits,
  output logic            bclk_q,
  output logic            lr_q,
  output logic            rise_q,
  output logic            fall_q
);
  localparam int CNT_W = $clog2(MAX_BITS);
  localparam int FRM_W = CNT_W + 1;

  logic             pre;
  logic             bclk_r;
  logic [CNT_W-1:0] bitcnt;
  logic [FRM_W-1:0] frame;
  logic [FRM_W-1:0] half;
  logic [CNT_W-1:0] half_mask;
  logic [CNT_W-1:0] bit_n;
  logic [CNT_W-1:0] pos_n;
  logic             tick;
  logic             bclk_n;
  logic             lr_n;
  logic             gate_ok;

  always_comb begin
    case (wdiv)
      WD_32:   frame = FRM_W'(32);
      WD_64:   frame = FRM_W'(64);
      default: frame = FRM_W'(128);
    endcase
  end

  assign half      = frame >> 1;
  assign half_mask = CNT_W'(half - FRM_W'(1));
  assign tick      = div4 ? pre : 1'b1;
  assign bclk_n    = bclk_r ^ tick;

  always_comb begin
    bit_n = bitcnt;
    if (tick && bclk_r) begin
      if ({1'b0, bitcnt} == frame - FRM_W'(1)) bit_n = '0;
      else                                     bit_n = bitcnt + CNT_W'(1);
    end
  end

  assign lr_n    = ({1'b0, bit_n} >= half);
  assign pos_n   = bit_n & half_mask;
  assign gate_ok = free_run | (int'(pos_n) < int'(valid_bits));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre    <= 1'b0;
      bclk_r <= 1'b0;
      bitcnt <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      pre    <= tick ? 1'b0 : ~pre;
      bclk_r <= bclk_n;
      bitcnt <= bit_n;
      bclk_q <= bclk_n & gate_ok;
      lr_q   <= lr_n;
      rise_q <= tick & ~bclk_r;
      fall_q <= tick & bclk_r;
    end
  end
endmodule

// File: rtl/aclk_slave_sync.sv
module aclk_slave_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ext_bclk,
  input  logic ext_lr,
  output logic rise_q,
  output logic fall_q,
  output logic ws_q
);
  logic [1:0] ext_in;
  logic [1:0] cur;
  logic [1:0] prev;

  assign ext_in = {ext_lr, ext_bclk};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    logic                   hist;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        hist  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], ext_in[g]};
        hist  <= chain[SYNC_STAGES-1];
      end
    end
    assign cur[g]  = chain[SYNC_STAGES-1];
    assign prev[g] = hist;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      rise_q <= en & cur[0] & ~prev[0];
      fall_q <= en & ~cur[0] & prev[0];
      ws_q   <= en & cur[1];
    end
  end
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int RATIO_W     = 12,
  parameter int MAX_BITS    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic               master,
  input  logic               free_run,
  input  logic               auto_div,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               man_div4,
  input  logic [1:0]         man_wsel,
  input  logic [1:0]         wlen_sel,
  input  logic               ext_bclk,
  input  logic               ext_lrclk,
  output logic               bclk_o,
  output logic               lrclk_o,
  output logic               clk_oe,
  output logic               bit_rise,
  output logic               bit_fall,
  output logic               word_sel
);
  localparam int VB_W = 6;

  logic            active;
  logic            div4;
  wdiv_e           wdiv;
  logic [VB_W-1:0] valid_bits;
  logic            m_bclk, m_lr, m_rise, m_fall;
  logic            s_rise, s_fall, s_ws;
  logic            oe_q;

  assign active = glb_en & (tx_en | rx_en);

  always_comb begin
    case (wlen_sel)
      2'd0:    valid_bits = VB_W'(16);
      2'd1:    valid_bits = VB_W'(24);
      default: valid_bits = VB_W'(32);
    endcase
  end

  aclk_rate_pick #(.RATIO_W(RATIO_W)) u_pick (
    .auto_en  (auto_div),
    .ratio    (ratio),
    .man_div4 (man_div4),
    .man_wsel (man_wsel),
    .div4     (div4),
    .wdiv     (wdiv)
  );

  aclk_master_div #(.MAX_BITS(MAX_BITS), .VB_W(VB_W)) u_mdiv (
    .clk        (clk),
    .rst        (rst),
    .run        (active & master),
    .div4       (div4),
    .wdiv       (wdiv),
    .free_run   (free_run),
    .valid_bits (valid_bits),
    .bclk_q     (m_bclk),
    .lr_q       (m_lr),
    .rise_q     (m_rise),
    .fall_q     (m_fall)
  );

  aclk_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ssync (
    .clk      (clk),
    .rst      (rst),
    .en       (active & ~master),
    .ext_bclk (ext_bclk),
    .ext_lr   (ext_lrclk),
    .rise_q   (s_rise),
    .fall_q   (s_fall),
    .ws_q     (s_ws)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= master & active;
  end

  assign bclk_o   = m_bclk;
  assign lrclk_o  = m_lr;
  assign clk_oe   = oe_q;
  assign bit_rise = m_rise | s_rise;
  assign bit_fall = m_fall | s_fall;
  assign word_sel = m_lr | s_ws;
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic glb_en,
  input logic tx_en,
  input logic rx_en,
  input logic master,
  input logic free_run,
  input logic bclk_o,
  input logic lrclk_o,
  input logic clk_oe,
  input logic bit_rise,
  input logic bit_fall,
  input logic word_sel
);
  logic act;
  assign act = glb_en & (tx_en | rx_en);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !act |=> (!bclk_o && !lrclk_o && !clk_oe && !bit_rise && !bit_fall && !word_sel));

  p_oe_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_oe == $past(master && act)));

  p_lr_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (master && act) |=> (lrclk_o == $past(lrclk_o) || bit_fall));

  p_rise_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    bit_rise |=> !bit_rise);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(bit_rise && bit_fall));

  p_rise_high_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_rise && $past(master && act && free_run)) |-> bclk_o);
endmodule

bind aclk_gen aclk_gen_chk u_chk (.*);

// File: tb/aclk_gen_bench.sv
module aclk_gen_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 0, tx_en = 0, rx_en = 0, master = 1, free_run = 1, auto_div = 0;
  logic [11:0] ratio = '0;
  logic man_div4 = 0;
  logic [1:0] man_wsel = 0, wlen_sel = 2;
  logic ext_bclk = 0, ext_lrclk = 0;
  logic bclk_o, lrclk_o, clk_oe, bit_rise, bit_fall, word_sel;

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  aclk_gen u_aclk_gen (
    .clk(clk), .rst(rst), .glb_en(glb_en), .tx_en(tx_en), .rx_en(rx_en),
    .master(master), .free_run(free_run), .auto_div(auto_div), .ratio(ratio),
    .man_div4(man_div4), .man_wsel(man_wsel), .wlen_sel(wlen_sel),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .clk_oe(clk_oe), .bit_rise(bit_rise), .bit_fall(bit_fall), .word_sel(word_sel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_pre = 0, m_bclk = 0, m_bit = 0;
  int s1b = 0, s2b = 0, s3b = 0, s1l = 0, s2l = 0;
  bit e_bclk = 0, e_lr = 0, e_oe = 0, e_rise = 0, e_fall = 0, e_ws = 0;
  bit m_act = 0, m_mst = 0, m_free = 1;

  always @(posedge clk) begin : model
    int d, w, l, h, nbit, nb, pos;
    bit tick, act;
    if (rst) begin
      m_pre = 0; m_bclk = 0; m_bit = 0;
      s1b = 0; s2b = 0; s3b = 0; s1l = 0; s2l = 0;
      {e_bclk, e_lr, e_oe, e_rise, e_fall, e_ws} = '0;
      m_act = 0;
    end else begin
      act = glb_en && (tx_en || rx_en);
      if (auto_div) begin
        if (ratio > 384) begin d = 4; w = 128; end
        else begin w = 64; d = (ratio < 192) ? 2 : 4; end
      end else begin
        d = man_div4 ? 4 : 2;
        w = (man_wsel == 0) ? 32 : (man_wsel == 1) ? 64 : 128;
      end
      l = (wlen_sel == 0) ? 16 : (wlen_sel == 1) ? 24 : 32;
      h = d / 2;
      e_oe = master && act;
      if (act && master) begin
        tick = (m_pre == h - 1);
        nbit = m_bit;
        if (tick && m_bclk == 1) nbit = (m_bit == w - 1) ? 0 : m_bit + 1;
        nb = tick ? 1 - m_bclk : m_bclk;
        pos = nbit % (w / 2);
        e_bclk = (nb == 1) && (free_run || pos < l);
        e_lr = (nbit >= w / 2);
        e_rise = tick && m_bclk == 0;
        e_fall = tick && m_bclk == 1;
        e_ws = e_lr;
        m_pre = tick ? 0 : m_pre + 1;
        m_bclk = nb; m_bit = nbit;
      end else begin
        m_pre = 0; m_bclk = 0; m_bit = 0;
        e_bclk = 0; e_lr = 0;
        e_rise = act && s2b == 1 && s3b == 0;
        e_fall = act && s2b == 0 && s3b == 1;
        e_ws = act && s2l == 1;
      end
      s3b = s2b; s2b = s1b; s1b = int'(ext_bclk);
      s2l = s1l; s1l = int'(ext_lrclk);
      m_act = act; m_mst = master; m_free = free_run;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check(bclk_o == e_bclk, !m_act ? "R2" : (!m_free ? "R10" : "R3"), bclk_o, e_bclk);
      check(lrclk_o == e_lr, !m_act ? "R2" : "R4", lrclk_o, e_lr);
      check(clk_oe == e_oe, "R8", clk_oe, e_oe);
      check(bit_rise == e_rise, !m_act ? "R2" : (m_mst ? "R11" : "R9"), bit_rise, e_rise);
      check(bit_fall == e_fall, !m_act ? "R2" : (m_mst ? "R11" : "R9"), bit_fall, e_fall);
      check(word_sel == e_ws, !m_act ? "R2" : (m_mst ? "R4" : "R9"), word_sel, e_ws);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic meas_lr(output int per);
    logic p;
    bit found;
    per = -1; found = 0;
    p = lrclk_o;
    for (int i = 0; i < 2000 && !found; i++) begin
      @(negedge clk);
      if (lrclk_o && !p) found = 1;
      p = lrclk_o;
    end
    if (!found) return;
    for (int i = 1; i < 2000; i++) begin
      @(negedge clk);
      if (lrclk_o && !p) begin per = i; return; end
      p = lrclk_o;
    end
  endtask

  task automatic stop_unit();
    glb_en = 0; tx_en = 0; rx_en = 0;
    cycles(3);
  endtask

  task automatic run_period(input string tag, input int exp);
    int per;
    glb_en = 1; tx_en = 1;
    meas_lr(per);
    check(per == exp, tag, per, exp);
    cycles(exp + 7);
    stop_unit();
  endtask

  initial begin : wd
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check(bclk_o == 0 && lrclk_o == 0 && clk_oe == 0 && bit_rise == 0, "R1", bclk_o, 0);
    @(negedge clk) rst = 0;
    cycles(1);
    check({bclk_o, lrclk_o, clk_oe, bit_rise, bit_fall, word_sel} == 0, "R1",
          {bclk_o, lrclk_o, clk_oe, bit_rise, bit_fall, word_sel}, 0);
    cmp_on = 1;

    // R7 manual selections
    man_div4 = 0; man_wsel = 0; run_period("R7 d2 w32", 64);
    man_div4 = 1; man_wsel = 1; run_period("R7 d4 w64", 256);
    man_div4 = 1; man_wsel = 2; run_period("R7 d4 w128", 512);
    man_div4 = 0; man_wsel = 3; run_period("R7 d2 wsel3", 256);

    // R6 automatic rule incl. boundaries
    auto_div = 1;
    ratio = 12'd500; run_period("R6 ratio500", 512);
    ratio = 12'd384; run_period("R6 ratio384", 256);
    ratio = 12'd385; run_period("R6 ratio385", 512);
    ratio = 12'd192; run_period("R6 ratio192", 256);
    ratio = 12'd191; run_period("R6 ratio191", 128);
    auto_div = 0;

    // R5 restart from zero, D=4 and D=2
    begin : r5
      int n;
      man_div4 = 1; man_wsel = 1;
      glb_en = 1; rx_en = 1; n = 0;
      for (int i = 0; i < 20 && !bclk_o; i++) begin @(negedge clk); n++; end
      check(n == 2, "R5 first rise d4", n, 2);
      check(lrclk_o == 0, "R5 lr starts low", lrclk_o, 0);
      cycles(37);
      stop_unit();
      man_div4 = 0;
      glb_en = 1; tx_en = 1; n = 0;
      for (int i = 0; i < 20 && !bclk_o; i++) begin @(negedge clk); n++; end
      check(n == 1, "R5 first rise d2", n, 1);
      cycles(50);
    end

    // R2 drop enables mid-run, then global only
    glb_en = 0;
    @(negedge clk);
    check({bclk_o, lrclk_o, clk_oe, bit_rise, bit_fall, word_sel} == 0, "R2 glb off",
          {bclk_o, lrclk_o, clk_oe, bit_rise, bit_fall, word_sel}, 0);
    glb_en = 1; tx_en = 0; rx_en = 0;
    cycles(4);
    check(clk_oe == 0 && bclk_o == 0, "R2 no direction", clk_oe, 0);
    stop_unit();

    // R10 gating: D=2, W=64, width 16 -> 32 clocked bits per frame
    begin : r10
      int per, rises;
      logic p;
      man_div4 = 0; man_wsel = 1; wlen_sel = 0; free_run = 0;
      glb_en = 1; tx_en = 1;
      meas_lr(per);
      rises = 0; p = bclk_o;
      for (int i = 0; i < 128; i++) begin
        @(negedge clk);
        if (bclk_o && !p) rises++;
        p = bclk_o;
      end
      check(rises == 32, "R10 gated rises", rises, 32);
      wlen_sel = 1;
      stop_unit();
      glb_en = 1; tx_en = 1;
      cycles(300);
      stop_unit();
      free_run = 1; wlen_sel = 2;
    end

    // R8/R9 slave mode
    begin : slave
      int n;
      master = 0; glb_en = 1; rx_en = 1;
      cycles(5);
      check(clk_oe == 0 && bclk_o == 0 && lrclk_o == 0, "R8 slave pins", clk_oe, 0);
      ext_bclk = 1; n = 0;
      for (int i = 0; i < 10 && !bit_rise; i++) begin @(negedge clk); n++; end
      check(n == 3, "R9 rise latency", n, 3);
      @(negedge clk);
      check(bit_rise == 0, "R9 one-cycle pulse", bit_rise, 0);
      ext_lrclk = 1;
      cycles(3);
      check(word_sel == 1, "R9 word_sel follows", word_sel, 1);
      for (int i = 0; i < 240; i++) begin
        @(negedge clk);
        if (i % 3 == 0) ext_bclk = ~ext_bclk;
        if (i % 48 == 0) ext_lrclk = ~ext_lrclk;
      end
      stop_unit();
      master = 1;
    end

    cycles(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule